// File: doc/BRIEF.md
# Dual-Issue Forwarding Register File

This block holds the general-purpose integer registers of a core that issues two instructions per cycle into two parallel pipes, called lane 0 (older instruction) and lane 1 (younger instruction). Each lane owns two read ports and one write port, so the block has four combinational read ports and two write ports in total. Both lanes may write in the same cycle.

Every read port also sees writes from the current cycle. If either write port targets the register a read port addresses, the read returns the incoming write data in that same cycle and does not wait for the register to update. Register index zero is fixed at zero: reads of it return zero, and writes to it are dropped on both ports. When both lanes write the same non-zero register in one cycle, lane 1 wins, because it holds the later instruction in program order. The same rule applies to the stored value and to the forwarded value.

Top module: `dual_issue_regfile`

## Requirements
- R1: The block holds NREGS (default 32) registers of XLEN bits (default 64). Each register is addressed by a log2(NREGS)-bit index.
- R2: A read of index 0 returns zero on every read port, whatever writes are in flight.
- R3: A write to index 0 on either write port is discarded. Later reads of index 0 still return zero.
- R4: A write with its enable high and a non-zero address updates that register at the next rising clock edge. Reads in later cycles return the written value.
- R5: Each of the four read ports is combinational in its address. Any register can be read on any port in any cycle, independently of the other ports.
- R6: When write port 0 is enabled with a non-zero address, any read port with the same address returns port 0's write data in the same cycle.
- R7: When write port 1 is enabled with a non-zero address, any read port with the same address returns port 1's write data in the same cycle.
- R8: When both write ports are enabled with the same non-zero address, port 1's data is both stored and forwarded.
- R9: A write port whose enable is low neither updates storage nor forwards its data.
- R10: A synchronous active-high reset clears every register to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| rd_addr | input | 4*AW | Read addresses; port k uses bits [k*AW +: AW] |
| rd_data | output | 4*XLEN | Read data; port k uses bits [k*XLEN +: XLEN] |
| wr_en | input | 2 | Write enables; bit k belongs to write port k |
| wr_addr | input | 2*AW | Write addresses; port k uses bits [k*AW +: AW] |
| wr_data | input | 2*XLEN | Write data; port k uses bits [k*XLEN +: XLEN] |

AW is log2(NREGS), which is 5 with the default parameters.

## Verification
Three things can coincide in one cycle: a write from each lane to the same register, and a read of that register. The bench creates this collision on purpose in directed cases, including with register zero as the target. It also draws random traffic over a small address pool so that collisions happen often. In every case, the same-cycle read value and the value read back in the next cycle are compared against a bench model that applies lane 1 over lane 0.

// File: rtl/rf_pkg.sv
package rf_pkg;
    localparam int NRD = 4;
    localparam int NWR = 2;

    typedef struct packed {
        logic        en;
        logic [4:0]  addr;
    } wr_ctl_t;

    // Returns 1 when a write is enabled and its address is non-zero.
    function automatic logic wr_live(input logic en, input logic [31:0] addr);
        return en && (addr != 0);
    endfunction
endpackage

// File: rtl/rf_store.sv
module rf_store #(
    parameter int NREGS = 32,
    parameter int XLEN  = 64,
    localparam int AW   = $clog2(NREGS)
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [rf_pkg::NWR-1:0]       wr_live,
    input  logic [rf_pkg::NWR*AW-1:0]    wr_addr,
    input  logic [rf_pkg::NWR*XLEN-1:0]  wr_data,
    output logic [NREGS*XLEN-1:0]        regs_flat
);
    logic [XLEN-1:0] mem [NREGS];

    assign regs_flat[XLEN-1:0] = '0;

    for (genvar r = 1; r < NREGS; r++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                mem[r] <= '0;
            end else if (wr_live[1] && wr_addr[AW +: AW] == AW'(r)) begin
                mem[r] <= wr_data[XLEN +: XLEN];   // lane 1 wins a collision
            end else if (wr_live[0] && wr_addr[0 +: AW] == AW'(r)) begin
                mem[r] <= wr_data[0 +: XLEN];
            end
        end
        assign regs_flat[r*XLEN +: XLEN] = mem[r];
    end
    assign mem[0] = '0;

    // R10: after a reset cycle, every register holds zero
    p_reset_clear_r10: assert property (@(posedge clk)
        $past(rst) |-> (regs_flat == '0));
endmodule

// File: rtl/rf_read_port.sv
module rf_read_port #(
    parameter int NREGS = 32,
    parameter int XLEN  = 64,
    localparam int AW   = $clog2(NREGS)
) (
    input  logic [AW-1:0]                addr,
    input  logic [NREGS*XLEN-1:0]        regs_flat,
    input  logic [rf_pkg::NWR-1:0]       wr_live,
    input  logic [rf_pkg::NWR*AW-1:0]    wr_addr,
    input  logic [rf_pkg::NWR*XLEN-1:0]  wr_data,
    output logic [XLEN-1:0]              data
);
    logic hit0, hit1;

    always_comb begin
        hit0 = wr_live[0] && (wr_addr[0 +: AW] == addr);
        hit1 = wr_live[1] && (wr_addr[AW +: AW] == addr);
        if (addr == '0)
            data = '0;
        else if (hit1)
            data = wr_data[XLEN +: XLEN];
        else if (hit0)
            data = wr_data[0 +: XLEN];
        else
            data = regs_flat[addr*XLEN +: XLEN];
    end

    // R2: index zero always reads zero
    always_comb p_zero_read_r2: assert (addr != '0 || data == '0);
    // R8: lane 1 data is returned when lane 1 hits
    always_comb p_lane1_wins_r8: assert (!(hit1 && addr != '0) || data == wr_data[XLEN +: XLEN]);
endmodule

// File: rtl/dual_issue_regfile.sv
module dual_issue_regfile #(
    parameter int NREGS = 32,
    parameter int XLEN  = 64,
    localparam int AW   = $clog2(NREGS)
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [rf_pkg::NRD*AW-1:0]    rd_addr,
    output logic [rf_pkg::NRD*XLEN-1:0]  rd_data,
    input  logic [rf_pkg::NWR-1:0]       wr_en,
    input  logic [rf_pkg::NWR*AW-1:0]    wr_addr,
    input  logic [rf_pkg::NWR*XLEN-1:0]  wr_data
);
    import rf_pkg::*;

    logic [NWR-1:0]        live;
    logic [NREGS*XLEN-1:0] regs_flat;

    for (genvar w = 0; w < NWR; w++) begin : g_live
        assign live[w] = wr_live(wr_en[w], 32'(wr_addr[w*AW +: AW]));
    end

    rf_store #(.NREGS(NREGS), .XLEN(XLEN)) u_store (
        .clk(clk), .rst(rst), .wr_live(live), .wr_addr(wr_addr),
        .wr_data(wr_data), .regs_flat(regs_flat)
    );

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        rf_read_port #(.NREGS(NREGS), .XLEN(XLEN)) u_port (
            .addr(rd_addr[p*AW +: AW]), .regs_flat(regs_flat),
            .wr_live(live), .wr_addr(wr_addr), .wr_data(wr_data),
            .data(rd_data[p*XLEN +: XLEN])
        );
    end

    // R4/R8: a committed write shows on read port 0 in the next cycle if addressed and not overwritten
    p_store_r4: assert property (@(posedge clk) disable iff (rst)
        (live[1] && rd_addr[0 +: AW] == wr_addr[AW +: AW]) ##1
        (rd_addr[0 +: AW] == $past(rd_addr[0 +: AW]) && !live[0] && !live[1])
        |-> rd_data[0 +: XLEN] == $past(wr_data[XLEN +: XLEN]));
    // R6: lane 0 forwards to read port 3 when lane 1 does not hit
    p_fwd0_r6: assert property (@(posedge clk) disable iff (rst)
        (live[0] && !live[1] && rd_addr[3*AW +: AW] == wr_addr[0 +: AW])
        |-> rd_data[3*XLEN +: XLEN] == wr_data[0 +: XLEN]);
    // R7: lane 1 forwards to read port 2
    p_fwd1_r7: assert property (@(posedge clk) disable iff (rst)
        (live[1] && rd_addr[2*AW +: AW] == wr_addr[AW +: AW])
        |-> rd_data[2*XLEN +: XLEN] == wr_data[XLEN +: XLEN]);
endmodule

// File: tb/test_dual_issue_regfile.sv
module test_dual_issue_regfile;
    localparam int NREGS = 32, XLEN = 64, AW = 5;

    logic clk = 0, rst = 1;
    logic [4*AW-1:0]   rd_addr = '0;
    logic [4*XLEN-1:0] rd_data;
    logic [1:0]        wr_en = '0;
    logic [2*AW-1:0]   wr_addr = '0;
    logic [2*XLEN-1:0] wr_data = '0;

    int checks = 0, errors = 0;
    logic [XLEN-1:0] model [NREGS];

    always #10 clk = ~clk;

    dual_issue_regfile #(.NREGS(NREGS), .XLEN(XLEN)) i_dual_issue_regfile (.*);

    function automatic logic [XLEN-1:0] expect_rd(input logic [AW-1:0] a);
        if (a == 0) return '0;
        if (wr_en[1] && wr_addr[AW +: AW] == a) return wr_data[XLEN +: XLEN];
        if (wr_en[0] && wr_addr[0 +: AW] == a) return wr_data[0 +: XLEN];
        return model[a];
    endfunction

    task automatic check(input string req, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Samples all four read ports against the model (mid-cycle), then commits at the edge.
    task automatic step(input string req);
        #5;
        for (int p = 0; p < 4; p++)
            check(req, rd_data[p*XLEN +: XLEN], expect_rd(rd_addr[p*AW +: AW]));
        @(posedge clk);
        if (wr_en[0] && wr_addr[0 +: AW] != 0) model[wr_addr[0 +: AW]] = wr_data[0 +: XLEN];
        if (wr_en[1] && wr_addr[AW +: AW] != 0) model[wr_addr[AW +: AW]] = wr_data[XLEN +: XLEN];
        #1;
    endtask

    task automatic drive(input logic [1:0] en, input int a0, input int a1,
                         input logic [XLEN-1:0] d0, input logic [XLEN-1:0] d1,
                         input int r0, input int r1, input int r2, input int r3);
        wr_en = en;
        wr_addr = {AW'(a1), AW'(a0)};
        wr_data = {d1, d0};
        rd_addr = {AW'(r3), AW'(r2), AW'(r1), AW'(r0)};
    endtask

    initial begin
        #2_000_000;
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(1234));
        for (int i = 0; i < NREGS; i++) model[i] = '0;
        // preload garbage while reset is held; reset must clear it
        drive(2'b11, 3, 4, 64'hdead, 64'hbeef, 0, 0, 0, 0);
        @(posedge clk); @(posedge clk); #1;
        rst = 0;
        drive(2'b00, 0, 0, 0, 0, 3, 4, 31, 1);
        step("R10 reset clear");
        // R4 basic write then read
        drive(2'b01, 5, 0, 64'h1111_2222_3333_4444, 0, 7, 8, 9, 10);
        step("R4 write");
        drive(2'b00, 0, 0, 0, 0, 5, 5, 5, 5);
        step("R4 readback");
        // R6 lane 0 forward
        drive(2'b01, 9, 0, 64'haaaa, 0, 9, 1, 9, 2);
        step("R6 fwd lane0");
        // R7 lane 1 forward
        drive(2'b10, 0, 12, 0, 64'hbbbb, 12, 12, 3, 12);
        step("R7 fwd lane1");
        // R8 collision
        drive(2'b11, 14, 14, 64'h0101, 64'h0202, 14, 14, 14, 14);
        step("R8 collision same cycle");
        drive(2'b00, 0, 0, 0, 0, 14, 14, 14, 14);
        step("R8 collision stored");
        // R3/R2 writes to zero
        drive(2'b11, 0, 0, 64'hffff, 64'heeee, 0, 0, 0, 0);
        step("R2 R3 zero write");
        drive(2'b00, 0, 0, 0, 0, 0, 0, 0, 0);
        step("R3 zero after write");
        // R9 disabled write
        drive(2'b00, 20, 21, 64'h7777, 64'h8888, 20, 21, 20, 21);
        step("R9 disabled same cycle");
        drive(2'b00, 0, 0, 0, 0, 20, 21, 20, 21);
        step("R9 disabled stored");
        // R1/R5 top register and independent ports
        drive(2'b01, 31, 0, 64'hffff_ffff_ffff_ffff, 0, 0, 0, 0, 0);
        step("R1 top register");
        drive(2'b00, 0, 0, 0, 0, 31, 5, 14, 0);
        step("R5 mixed ports");
        // random traffic over small pool to force collisions
        for (int n = 0; n < 2000; n++) begin
            drive($urandom_range(3, 0), $urandom_range(3, 0), $urandom_range(3, 0),
                  {$urandom, $urandom}, {$urandom, $urandom},
                  $urandom_range(3, 0), $urandom_range(3, 0),
                  $urandom_range(3, 0), $urandom_range(31, 0));
            step("R5 R6 R7 R8 random");
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule